// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request from a group of sixteen lanes and splits it into the smallest set of aligned bus transactions. Each lane gives a byte address of a 4-byte word and an active bit. One mode input chooses between two merge rules. Sequential mode merges only a perfectly ordered lane-to-word pattern. Segment mode merges every lane that lands in the same aligned 128-byte segment, then shrinks that segment to 64 or 32 bytes when the touched lanes allow it.

A group is accepted on a valid/ready handshake, but only while the block is idle. The block then issues one transaction per handshake on its output. Each transaction carries a size-aligned base address, a size code and the mask of the lanes it serves. A one-cycle done pulse marks that the group has drained. After the pulse the block accepts the next group. Data return is not handled here.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, in_ready is 1, and out_valid and done are 0.
- R2: A group is captured on in_valid && in_ready. in_ready stays 0 from the capture until the cycle after done.
- R3: In segment mode (in_strict=0), the block takes the lowest-numbered pending lane as leader. It serves, in one transaction, every pending lane whose address shares the leader's 128-byte segment. Transactions come out in ascending order of leader lane.
- R4: A segment transaction is 128 bytes when its lanes touch both 64-byte halves of the segment (address bit 6 differs).
- R5: Otherwise it is 64 bytes when its lanes touch two 32-byte quarters (bits 6:5 differ), and 32 bytes when they touch only one quarter.
- R6: out_size encodes 0 as 32 bytes, 1 as 64 bytes and 2 as 128 bytes. out_base is aligned to that size, and out_mask bit n stands for lane n.
- R7: In sequential mode (in_strict=1), let L be the lowest active lane. If addr[L]-4*L is 64-byte aligned and every active lane n has address addr[L]-4*L+4*n, the group gives one 64-byte transaction at that base. Its mask equals the active set.
- R8: Any other pattern in sequential mode gives one 32-byte transaction per active lane, in ascending lane order. Each base is the lane address with bits 4:0 cleared.
- R9: Inactive lanes are never served and their addresses have no effect. A group with no active lane gives no transaction, and done is high in the cycle after capture.
- R10: A transaction retires on out_valid && out_ready. While out_valid && !out_ready, out_base, out_size and out_mask hold steady.
- R11: done is high for exactly one cycle, in the cycle after the last transaction retires. It is followed by in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Group request present |
| in_ready | output | 1 | Block idle, group may be captured |
| in_strict | input | 1 | 1 = sequential rule, 0 = segment rule |
| in_active | input | LANES | Per-lane active bits |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane n at bits n*ADDR_W upward |
| out_valid | output | 1 | Transaction present |
| out_ready | input | 1 | Consumer takes transaction |
| out_base | output | ADDR_W | Size-aligned transaction base |
| out_size | output | 2 | 0: 32 B, 1: 64 B, 2: 128 B |
| out_mask | output | LANES | Lanes served by the transaction |
| done | output | 1 | Group fully drained |

## Verification
The bench builds the block with LANES=16, ADDR_W=32 and SEG_BYTES=128. With these values a 64-byte region holds exactly one word per lane, so the sequential rule's ordered case, the boundary-straddling split (offsets 68 to 131) and the sixteen-segment worst case can all be driven exactly. Out_ready follows a periodic stall pattern, so every group also runs with held transactions. Partial active masks with junk addresses on idle lanes reach the lane-skipping paths in both modes.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        SZ_32B  = 2'd0,
        SZ_64B  = 2'd1,
        SZ_128B = 2'd2
    } xfer_size_e;
endpackage

// File: rtl/coal_lowest.sv
module coal_lowest #(
    parameter int N = 16
) (
    input  logic [N-1:0]         vec,
    output logic [$clog2(N)-1:0] idx,
    output logic                 found
);
    localparam int IW = $clog2(N);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_strict_check.sv
module coal_strict_check #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        active,
    output logic                    merge,
    output logic [ADDR_W-1:0]       base
);
    localparam int REGION_LSB = $clog2(LANES * 4);
    localparam int LIDX_W     = $clog2(LANES);

    logic [ADDR_W-1:0] lane_a [LANES];
    logic [LIDX_W-1:0] first;
    logic              any;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_a[g] = addr_flat[g*ADDR_W +: ADDR_W];
    end

    coal_lowest #(.N(LANES)) u_first (
        .vec   (active),
        .idx   (first),
        .found (any)
    );

    always_comb begin
        base  = lane_a[first] - (ADDR_W'(first) << 2);
        merge = any && (base[REGION_LSB-1:0] == '0);
        for (int i = 0; i < LANES; i++) begin
            if (active[i] && (lane_a[i] != base + (ADDR_W'(i) << 2))) begin
                merge = 1'b0;
            end
        end
    end
endmodule

// File: rtl/coal_segment_pick.sv
module coal_segment_pick
    import coal_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic [LANES*ADDR_W-1:0]  addr_flat,
    input  logic [LANES-1:0]         pending,
    input  logic [$clog2(LANES)-1:0] lead,
    output logic [LANES-1:0]         mask,
    output logic [ADDR_W-1:0]        base,
    output logic [1:0]               size
);
    localparam int SEG_LSB = $clog2(SEG_BYTES);
    localparam int QTR_LSB = SEG_LSB - 2;

    logic [ADDR_W-1:0] lane_a [LANES];
    logic [ADDR_W-1:0] lead_a;
    logic              split_half, split_qtr;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_a[g] = addr_flat[g*ADDR_W +: ADDR_W];
    end

    always_comb begin
        lead_a     = lane_a[lead];
        mask       = '0;
        split_half = 1'b0;
        split_qtr  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && lane_a[i][ADDR_W-1:SEG_LSB] == lead_a[ADDR_W-1:SEG_LSB]) begin
                mask[i] = 1'b1;
                if (lane_a[i][SEG_LSB-1] != lead_a[SEG_LSB-1])
                    split_half = 1'b1;
                if (lane_a[i][SEG_LSB-1:QTR_LSB] != lead_a[SEG_LSB-1:QTR_LSB])
                    split_qtr = 1'b1;
            end
        end
        if (split_half) begin
            size = SZ_128B;
            base = lead_a & ~ADDR_W'(SEG_BYTES - 1);
        end else if (split_qtr) begin
            size = SZ_64B;
            base = lead_a & ~ADDR_W'(SEG_BYTES / 2 - 1);
        end else begin
            size = SZ_32B;
            base = lead_a & ~ADDR_W'(SEG_BYTES / 4 - 1);
        end
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_strict,
    input  logic [LANES-1:0]        in_active,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_base,
    output logic [1:0]              out_size,
    output logic [LANES-1:0]        out_mask,
    output logic                    done
);
    localparam int LIDX_W = $clog2(LANES);
    localparam int AW_TOT = LANES * ADDR_W;
    localparam int MIN_B  = SEG_BYTES / 4;

    typedef struct packed {
        logic              busy;
        logic              strict;
        logic              merge;
        logic [LANES-1:0]  pending;
        logic [ADDR_W-1:0] mbase;
        logic [AW_TOT-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    logic              merge_w;
    logic [ADDR_W-1:0] mbase_w;
    logic [LIDX_W-1:0] lead_idx;
    logic              lead_found;
    logic [LANES-1:0]  seg_mask;
    logic [ADDR_W-1:0] seg_base;
    logic [1:0]        seg_size;
    logic [ADDR_W-1:0] lead_addr;

    coal_strict_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_strict (
        .addr_flat (in_addr),
        .active    (in_active),
        .merge     (merge_w),
        .base      (mbase_w)
    );

    coal_lowest #(.N(LANES)) u_lead (
        .vec   (st_q.pending),
        .idx   (lead_idx),
        .found (lead_found)
    );

    coal_segment_pick #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_seg (
        .addr_flat (st_q.addr),
        .pending   (st_q.pending),
        .lead      (lead_idx),
        .mask      (seg_mask),
        .base      (seg_base),
        .size      (seg_size)
    );

    assign lead_addr = st_q.addr[lead_idx*ADDR_W +: ADDR_W];
    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy && lead_found;
    assign done      = st_q.busy && !lead_found;

    always_comb begin
        st_d = st_q;
        if (st_q.strict) begin
            if (st_q.merge) begin
                out_mask = st_q.pending;
                out_base = st_q.mbase;
                out_size = SZ_64B;
            end else begin
                out_mask = LANES'(1) << lead_idx;
                out_base = lead_addr & ~ADDR_W'(MIN_B - 1);
                out_size = SZ_32B;
            end
        end else begin
            out_mask = seg_mask;
            out_base = seg_base;
            out_size = seg_size;
        end

        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy    = 1'b1;
                st_d.strict  = in_strict;
                st_d.merge   = merge_w;
                st_d.pending = in_active;
                st_d.mbase   = mbase_w;
                st_d.addr    = in_addr;
            end
        end else begin
            if (out_valid && out_ready)
                st_d.pending = st_q.pending & ~out_mask;
            if (!lead_found)
                st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Assertions
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_base)
                                    && $stable(out_size) && $stable(out_mask));

    a_r6_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_size != 2'd3
                      && (out_base & ((ADDR_W'(MIN_B) << out_size) - 1)) == '0);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid && !done);

    a_r11_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready && !done);

    a_r9_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask != '0 && (out_mask & ~st_q.pending) == '0);

    a_r8_strict_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && st_q.strict && out_size == 2'd0 |-> $countones(out_mask) == 1);

    for (genvar g = 0; g < LANES; g++) begin : g_span
        a_r3_lane_in_span: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_mask[g] |->
                (st_q.addr[g*ADDR_W +: ADDR_W] - out_base) < (ADDR_W'(MIN_B) << out_size));
    end
endmodule

// File: tb/hw_coalescer_bench.sv
module hw_coalescer_bench;
    localparam int LANES = 16;
    localparam int AW    = 32;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic                  in_strict = 1'b0;
    logic [LANES-1:0]      in_active = '0;
    logic [LANES*AW-1:0]   in_addr = '0;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [AW-1:0]         out_base;
    logic [1:0]            out_size;
    logic [LANES-1:0]      out_mask;
    logic                  done;

    always #10 clk = ~clk;

    hw_coalescer #(.LANES(LANES), .ADDR_W(AW), .SEG_BYTES(128)) u_hw_coalescer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_strict(in_strict), .in_active(in_active), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
        .out_size(out_size), .out_mask(out_mask), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    logic [49:0] expq [$];
    string       tagq [$];
    logic [31:0] a [LANES];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] b, input logic [1:0] s, input logic [15:0] m, input string req);
        expq.push_back({b, s, m});
        tagq.push_back(req);
    endtask

    // Expected transactions from the requirements (R3-R5, R7-R9)
    task automatic model(input logic [15:0] act, input bit strict, input string req);
        logic [15:0] pend;
        logic [31:0] cand;
        logic [3:0]  tq;
        logic [15:0] m;
        bit          ok;
        int          l;
        pend = act;
        if (strict) begin
            l = 0;
            for (int i = LANES - 1; i >= 0; i--) if (act[i]) l = i;
            cand = a[l] - 32'(4 * l);
            ok = (act != 0) && (cand[5:0] == 0);
            for (int i = 0; i < LANES; i++)
                if (act[i] && a[i] != cand + 32'(4 * i)) ok = 0;
            if (ok) push(cand, 2'd1, act, req);
            else for (int i = 0; i < LANES; i++)
                if (act[i]) push(a[i] & ~32'd31, 2'd0, 16'(1) << i, req);
        end else begin
            while (pend != 0) begin
                l = 0;
                for (int i = LANES - 1; i >= 0; i--) if (pend[i]) l = i;
                tq = 0; m = 0;
                for (int i = 0; i < LANES; i++)
                    if (pend[i] && a[i][31:7] == a[l][31:7]) begin
                        m[i] = 1'b1;
                        tq[a[i][6:5]] = 1'b1;
                    end
                if (|tq[1:0] && |tq[3:2]) push(a[l] & ~32'd127, 2'd2, m, req);
                else if ($countones(tq) > 1) push(a[l] & ~32'd63, 2'd1, m, req);
                else push(a[l] & ~32'd31, 2'd0, m, req);
                pend &= ~m;
            end
        end
    endtask

    task automatic run_group(input logic [15:0] act, input bit strict, input string req);
        int n;
        model(act, strict, req);
        @(posedge clk); #2;
        while (!in_ready) begin @(posedge clk); #2; end
        for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a[i];
        in_active = act;
        in_strict = strict;
        in_valid  = 1'b1;
        @(posedge clk); #2;
        in_valid = 1'b0;
        if (act == 0) check(done == 1'b1, "R9 empty group done", 64'(done), 64'd1);
        else          check(in_ready == 1'b0, "R2 busy after capture", 64'(in_ready), 64'd0);
        n = 0;
        while (!done && n < 300) begin @(posedge clk); #2; n++; end
        check(done == 1'b1, {req, " done seen"}, 64'(done), 64'd1);
        check(expq.size() == 0, {req, " all transactions seen"}, 64'(expq.size()), 64'd0);
        @(posedge clk); #2;
        check(in_ready == 1'b1 && done == 1'b0, "R11 idle after done", {in_ready, done}, 64'd2);
        expq.delete();
        tagq.delete();
    endtask

    // Monitor: compare each retired transaction (R6, R10)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected transaction", {out_base, out_size, out_mask}, 64'd0);
            end else begin
                logic [49:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({out_base, out_size, out_mask} == e, {t, " R6 transaction"},
                      64'({out_base, out_size, out_mask}), 64'(e));
            end
        end
    end

    int rcnt = 0;
    initial forever begin
        @(posedge clk); #5;
        out_ready = (rcnt % 3) != 2;
        rcnt++;
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !done, "R1 reset state",
              {in_ready, out_valid, done}, 64'h4);

        // R5: 16 consecutive words, 64-byte aligned -> one 64B
        for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(4 * i);
        run_group(16'hFFFF, 1'b0, "R5 aligned run");
        // R4: stride-2 words spanning the whole segment -> one 128B
        for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 32'(8 * i);
        run_group(16'hFFFF, 1'b0, "R4 stride two");
        // R4/R5: offsets 68..131 -> 64B + 32B, never 128B
        for (int i = 0; i < LANES; i++) a[i] = 32'h3044 + 32'(4 * i);
        run_group(16'hFFFF, 1'b0, "R4 straddle");
        // R3: every lane in its own segment -> 16 x 32B
        for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 32'(128 * i);
        run_group(16'hFFFF, 1'b0, "R3 worst case");
        // R3: interleaved segments, lead order
        for (int i = 0; i < LANES; i++) a[i] = 32'h5000 + ((i % 2) ? 32'h200 : 32'h0) + 32'(4 * i);
        run_group(16'hFFFF, 1'b0, "R3 interleaved");
        // R5: all lanes same word -> one 32B
        for (int i = 0; i < LANES; i++) a[i] = 32'h6010;
        run_group(16'hFFFF, 1'b0, "R5 broadcast");
        // R9: inactive lanes carry junk
        for (int i = 0; i < LANES; i++) a[i] = 32'h9000 + 32'(256 * i);
        for (int i = 4; i < 8; i++) a[i] = 32'h7040 + 32'(4 * i);
        run_group(16'h00F0, 1'b0, "R9 partial segment");
        // R7: strict ordered -> one 64B
        for (int i = 0; i < LANES; i++) a[i] = 32'h8040 + 32'(4 * i);
        run_group(16'hFFFF, 1'b1, "R7 strict ordered");
        // R8: strict shifted by one word -> 16 x 32B
        for (int i = 0; i < LANES; i++) a[i] = 32'h8044 + 32'(4 * i);
        run_group(16'hFFFF, 1'b1, "R8 strict shifted");
        // R8: strict swapped lanes -> per lane
        for (int i = 0; i < LANES; i++) a[i] = 32'hA000 + 32'(4 * i);
        a[2] = 32'hA00C; a[3] = 32'hA008;
        run_group(16'hFFFF, 1'b1, "R8 strict swapped");
        // R7/R9: strict partial active, junk on idle lanes
        for (int i = 0; i < LANES; i++) a[i] = 32'hB080 + 32'(4 * i);
        a[0] = 32'hDEAD0; a[15] = 32'h1234;
        run_group(16'h7FFE, 1'b1, "R7 strict partial");
        // R9: empty group in both modes
        run_group(16'h0000, 1'b0, "R9 empty segment");
        run_group(16'h0000, 1'b1, "R9 empty strict");
        finish_run();
    end
endmodule